// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

This block is the control engine of a single DMA channel. It keeps a requester address, a target address and a transfer count, decides when to ask the bus for one data transfer, and steps the addresses and the count each time a transfer finishes. It does not run bus cycles itself. An outside bus engine sees `bus_req`, answers with `bus_gnt`, and reports each finished transfer with a one-cycle `xfer_done`.

Software loads the start values with a one-cycle `prog_load`, which also arms the channel. A request can come from a hardware line, which can be masked, or from a software pulse. Three data-transfer modes are supported. Single mode gives up the bus after every transfer. Block mode keeps the bus for the whole buffer. Demand mode keeps the bus while the hardware line stays high. At the end of a buffer the channel either stops or, with auto-reinitialise set, restores its programmed values and stays armed.

Top module: `dma_chan_seq`

## Requirements
- R1: After a synchronous active-low reset, `bus_req`, `tc`, `irq` and `chan_on` are 0, and `count`, `req_addr` and `tgt_addr` are 0.
- R2: With mode 0 (single), `bus_req` is low in the cycle after every `xfer_done`, and each further transfer needs a new request.
- R3: With mode 1 (block), one request holds `bus_req` high from the grant until the buffer ends.
- R4: With mode 2 (demand), `bus_req` stays high while `hw_req` is high when a transfer completes. If `hw_req` is low at a transfer completion, `bus_req` drops. Addresses and count are then kept unchanged, and a later request resumes the buffer from them.
- R5: In demand mode a `sw_req` pulse raises no request and changes no state.
- R6: With `cfg_hw_mask` set, `hw_req` is ignored and a `sw_req` pulse still starts a transfer. `bus_req` rises in the cycle after the pulse.
- R7: Each address steps once per transfer according to its direction field: 0 increments, 1 decrements, 2 or 3 holds. With the full bit at 1 the whole address steps; with it at 0 only the low 16 bits step, wrapping within those 16 bits.
- R8: `count` holds the number of transfers minus one and falls by one at each transfer, wrapping from 0 to all ones. `tc` goes high for exactly one cycle after a transfer that completes with `count` at 0.
- R9: Without auto-reinitialise the channel is disarmed at the end of a buffer (`chan_on` low). It then ignores all requests until the next `prog_load`.
- R10: With `cfg_autoinit` set, the end of a buffer restores the programmed addresses and count, and the channel stays armed.
- R11: If `eop` is high with `xfer_done`, the buffer ends at that transfer exactly as at terminal count: `tc` pulses and the auto-reinitialise reload applies.
- R12: `irq` equals `tc` when `cfg_tc_irq_en` is 1, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| prog_load | input | 1 | Load start values and arm the channel |
| req_addr_init | input | AW | Requester start address |
| tgt_addr_init | input | AW | Target start address |
| count_init | input | CW | Transfers minus one |
| cfg_xfer_mode | input | 2 | 0 single, 1 block, 2 demand, 3 treated as single |
| cfg_autoinit | input | 1 | Reload the programmed values at the end of a buffer |
| cfg_req_dir | input | 2 | Requester step: 0 inc, 1 dec, 2/3 hold |
| cfg_req_full | input | 1 | Requester steps the full width (1) or the low 16 bits (0) |
| cfg_tgt_dir | input | 2 | Target step: 0 inc, 1 dec, 2/3 hold |
| cfg_tgt_full | input | 1 | Target steps the full width (1) or the low 16 bits (0) |
| cfg_hw_mask | input | 1 | Ignore `hw_req` |
| cfg_tc_irq_en | input | 1 | Route `tc` to `irq` |
| hw_req | input | 1 | Hardware request level |
| sw_req | input | 1 | Software request pulse |
| eop | input | 1 | End the buffer at this transfer |
| bus_gnt | input | 1 | Bus granted |
| xfer_done | input | 1 | One transfer finished |
| bus_req | output | 1 | Bus request |
| req_addr | output | AW | Current requester address |
| tgt_addr | output | AW | Current target address |
| count | output | CW | Remaining transfers minus one |
| chan_on | output | 1 | Channel armed |
| tc | output | 1 | Terminal-count pulse |
| irq | output | 1 | Interrupt request |

## Verification
A table drives whole buffers in each transfer mode, each with a different mix of step directions and widths. The start addresses sit right at a 16-bit boundary or at a full-width boundary, so the final addresses show whether the carry is kept inside the low half or passes into the upper bits. The bus-request level after each completion separates single mode (released) from block and demand modes (held). Directed cases cover the rest: a demand-mode suspend and resume, masked hardware against a software pulse, a software pulse in demand mode, an early end-of-process with reload, and a reload at terminal count with the interrupt disabled.

// File: rtl/dma_seq_pkg.sv
// Shared encodings for the DMA channel sequencer.
package dma_seq_pkg;

    // Data-transfer mode field encoding.
    typedef enum logic [1:0] {
        XM_SINGLE = 2'd0,
        XM_BLOCK  = 2'd1,
        XM_DEMAND = 2'd2,
        XM_RSVD   = 2'd3
    } xfer_mode_e;

    // Address step direction field encoding.
    typedef enum logic [1:0] {
        SD_INC   = 2'd0,
        SD_DEC   = 2'd1,
        SD_HOLD  = 2'd2,
        SD_HOLDX = 2'd3
    } step_dir_e;

    // Channel sequencing states.
    typedef enum logic [1:0] {
        CH_OFF   = 2'd0,
        CH_ARMED = 2'd1,
        CH_ASK   = 2'd2,
        CH_XFER  = 2'd3
    } ch_state_e;

endpackage

// File: rtl/dma_addr_step.sv
// Next-address calculator for one side of the channel.
// It computes the address that follows `cur` after one transfer: increment,
// decrement or hold. The step covers either the whole address or only the
// low LOW_W bits, and in that case the upper bits never change.
// Assumes: purely combinational, step size of one unit per transfer.
module dma_addr_step
    import dma_seq_pkg::*;
#(
    parameter int AW    = 24,
    parameter int LOW_W = 16
) (
    input  logic [AW-1:0] cur,
    input  logic [1:0]    dir,
    input  logic          full,
    output logic [AW-1:0] nxt
);
    localparam int LW = (AW > LOW_W) ? LOW_W : AW;

    logic [AW-1:0] inc_full, dec_full, inc_low, dec_low;
    logic [LW-1:0] low_cur, low_inc, low_dec;

    assign inc_full = cur + AW'(1);
    assign dec_full = cur - AW'(1);
    assign low_cur  = cur[LW-1:0];
    assign low_inc  = low_cur + LW'(1);
    assign low_dec  = low_cur - LW'(1);

    generate
        if (AW > LW) begin : g_split
            assign inc_low = {cur[AW-1:LW], low_inc};
            assign dec_low = {cur[AW-1:LW], low_dec};
        end else begin : g_whole
            assign inc_low = low_inc;
            assign dec_low = low_dec;
        end
    endgenerate

    // Select the stepped address from direction and width.
    always_comb begin
        case (dir)
            SD_INC:  nxt = full ? inc_full : inc_low;
            SD_DEC:  nxt = full ? dec_full : dec_low;
            default: nxt = cur;
        endcase
    end

endmodule

// File: rtl/dma_chan_ctrl.sv
// Request qualification and bus sequencing for one DMA channel.
// It tracks the channel through off, armed, asking and transferring. It
// decides when to raise the bus request, when to release it (per transfer
// mode), and flags the end of a buffer (terminal count or end-of-process).
// Assumes: xfer_done only arrives while transferring; sw_req is a pulse.
module dma_chan_ctrl
    import dma_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       prog_load,
    input  logic [1:0] mode,
    input  logic       hw_mask,
    input  logic       hw_req,
    input  logic       sw_req,
    input  logic       bus_gnt,
    input  logic       xfer_done,
    input  logic       eop,
    input  logic       cnt_zero,
    input  logic       autoinit,
    output logic       bus_req,
    output logic       chan_on,
    output logic       in_xfer,
    output logic       step_en,
    output logic       reload,
    output logic       tc
);
    ch_state_e st, st_nxt;
    logic      sw_pend;
    logic      demand, hw_ok, sw_ok, start, buf_end;

    assign demand  = (mode == XM_DEMAND);
    assign hw_ok   = hw_req & ~hw_mask;
    assign sw_ok   = sw_req & ~demand;
    assign start   = hw_ok | sw_ok | (sw_pend & ~demand);
    assign in_xfer = (st == CH_XFER);
    assign step_en = in_xfer & xfer_done & ~prog_load;
    assign buf_end = step_en & (cnt_zero | eop);
    assign reload  = buf_end & autoinit;
    assign bus_req = (st == CH_ASK) | (st == CH_XFER);
    assign chan_on = (st != CH_OFF);

    // Next-state selection for the channel sequence.
    always_comb begin
        st_nxt = st;
        case (st)
            CH_OFF:   st_nxt = CH_OFF;
            CH_ARMED: if (start) st_nxt = CH_ASK;
            CH_ASK:   if (bus_gnt) st_nxt = CH_XFER;
            CH_XFER: begin
                if (step_en) begin
                    if (buf_end) begin
                        st_nxt = autoinit ? CH_ARMED : CH_OFF;
                    end else begin
                        case (mode)
                            XM_BLOCK:  st_nxt = CH_XFER;
                            XM_DEMAND: st_nxt = hw_ok ? CH_XFER : CH_ARMED;
                            default:   st_nxt = CH_ARMED;
                        endcase
                    end
                end
            end
            default:  st_nxt = CH_OFF;
        endcase
        if (prog_load) st_nxt = CH_ARMED;
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= CH_OFF;
        else        st <= st_nxt;
    end

    // Remember a software pulse until the channel next starts a request.
    always_ff @(posedge clk) begin
        if (!rst_n || prog_load)       sw_pend <= 1'b0;
        else if (st == CH_ARMED && start) sw_pend <= 1'b0;
        else if (sw_ok && st != CH_OFF)   sw_pend <= 1'b1;
    end

    // One-cycle terminal-count pulse after the buffer-ending transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) tc <= 1'b0;
        else        tc <= buf_end;
    end

endmodule

// File: rtl/dma_chan_seq.sv
// Top of the DMA channel transfer sequencer.
// Holds the programmed and current addresses of both sides and the count. It
// steps them on every completed transfer and reloads them when a buffer ends
// in auto-reinitialise mode. Sequencing is delegated to dma_chan_ctrl.
// Assumes: configuration fields are static while the channel is active.
module dma_chan_seq
    import dma_seq_pkg::*;
#(
    parameter int AW    = 24,
    parameter int CW    = 16,
    parameter int LOW_W = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          prog_load,
    input  logic [AW-1:0] req_addr_init,
    input  logic [AW-1:0] tgt_addr_init,
    input  logic [CW-1:0] count_init,
    input  logic [1:0]    cfg_xfer_mode,
    input  logic          cfg_autoinit,
    input  logic [1:0]    cfg_req_dir,
    input  logic          cfg_req_full,
    input  logic [1:0]    cfg_tgt_dir,
    input  logic          cfg_tgt_full,
    input  logic          cfg_hw_mask,
    input  logic          cfg_tc_irq_en,
    input  logic          hw_req,
    input  logic          sw_req,
    input  logic          eop,
    input  logic          bus_gnt,
    input  logic          xfer_done,
    output logic          bus_req,
    output logic [AW-1:0] req_addr,
    output logic [AW-1:0] tgt_addr,
    output logic [CW-1:0] count,
    output logic          chan_on,
    output logic          tc,
    output logic          irq
);
    localparam int NSIDE = 2;

    logic          in_xfer, step_en, reload;
    logic [CW-1:0] base_cnt, cur_cnt;
    logic [AW-1:0] side_init [NSIDE];
    logic [AW-1:0] side_cur  [NSIDE];
    logic [1:0]    side_dir  [NSIDE];
    logic          side_full [NSIDE];

    assign side_init[0] = req_addr_init;
    assign side_init[1] = tgt_addr_init;
    assign side_dir[0]  = cfg_req_dir;
    assign side_dir[1]  = cfg_tgt_dir;
    assign side_full[0] = cfg_req_full;
    assign side_full[1] = cfg_tgt_full;

    dma_chan_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .prog_load (prog_load),
        .mode      (cfg_xfer_mode),
        .hw_mask   (cfg_hw_mask),
        .hw_req    (hw_req),
        .sw_req    (sw_req),
        .bus_gnt   (bus_gnt),
        .xfer_done (xfer_done),
        .eop       (eop),
        .cnt_zero  (cur_cnt == '0),
        .autoinit  (cfg_autoinit),
        .bus_req   (bus_req),
        .chan_on   (chan_on),
        .in_xfer   (in_xfer),
        .step_en   (step_en),
        .reload    (reload),
        .tc        (tc)
    );

    for (genvar s = 0; s < NSIDE; s++) begin : g_side
        logic [AW-1:0] base_q, cur_q, nxt_a;

        dma_addr_step #(.AW(AW), .LOW_W(LOW_W)) u_step (
            .cur  (cur_q),
            .dir  (side_dir[s]),
            .full (side_full[s]),
            .nxt  (nxt_a)
        );

        // Programmed and current address of this side.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base_q <= '0;
                cur_q  <= '0;
            end else if (prog_load) begin
                base_q <= side_init[s];
                cur_q  <= side_init[s];
            end else if (reload) begin
                cur_q  <= base_q;
            end else if (step_en) begin
                cur_q  <= nxt_a;
            end
        end

        assign side_cur[s] = cur_q;
    end

    // Programmed and remaining transfer count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_cnt <= '0;
            cur_cnt  <= '0;
        end else if (prog_load) begin
            base_cnt <= count_init;
            cur_cnt  <= count_init;
        end else if (reload) begin
            cur_cnt  <= base_cnt;
        end else if (step_en) begin
            cur_cnt  <= cur_cnt - CW'(1);
        end
    end

    assign req_addr = side_cur[0];
    assign tgt_addr = side_cur[1];
    assign count    = cur_cnt;
    assign irq      = tc & cfg_tc_irq_en;

endmodule

// File: rtl/dma_chan_seq_chk.sv
// Property checker for dma_chan_seq, attached by bind below.
// Assumes: sampled on the rising clock edge, disabled during reset.
module dma_chan_seq_chk #(
    parameter int AW = 24,
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          prog_load,
    input logic [1:0]    cfg_xfer_mode,
    input logic          cfg_autoinit,
    input logic [1:0]    cfg_req_dir,
    input logic          cfg_hw_mask,
    input logic          hw_req,
    input logic          eop,
    input logic          xfer_done,
    input logic          bus_req,
    input logic          tc,
    input logic [CW-1:0] count,
    input logic [AW-1:0] req_addr,
    input logic          in_xfer,
    input logic          chan_on,
    input logic [CW-1:0] base_cnt
);
    logic done_ok;
    assign done_ok = in_xfer && xfer_done && !prog_load;

    assert_single_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (done_ok && cfg_xfer_mode == 2'd0) |=> !bus_req);

    assert_block_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done_ok && cfg_xfer_mode == 2'd1 && count != '0 && !eop) |=> bus_req);

    assert_demand_suspend_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done_ok && cfg_xfer_mode == 2'd2 && !(hw_req && !cfg_hw_mask)) |=> !bus_req);

    assert_hold_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_ok && cfg_req_dir == 2'd2 && !cfg_autoinit) |=> $stable(req_addr));

    assert_count_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_ok && !(cfg_autoinit && (count == '0 || eop))) |=> (count == $past(count) - CW'(1)));

    assert_tc_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tc |=> !tc);

    assert_off_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!chan_on && !prog_load) |=> !bus_req);

    assert_reload_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done_ok && cfg_autoinit && count == '0) |=> (count == base_cnt && chan_on));

endmodule

bind dma_chan_seq dma_chan_seq_chk #(.AW(AW), .CW(CW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .prog_load     (prog_load),
    .cfg_xfer_mode (cfg_xfer_mode),
    .cfg_autoinit  (cfg_autoinit),
    .cfg_req_dir   (cfg_req_dir),
    .cfg_hw_mask   (cfg_hw_mask),
    .hw_req        (hw_req),
    .eop           (eop),
    .xfer_done     (xfer_done),
    .bus_req       (bus_req),
    .tc            (tc),
    .count         (count),
    .req_addr      (req_addr),
    .in_xfer       (in_xfer),
    .chan_on       (chan_on),
    .base_cnt      (base_cnt)
);

// File: tb/test_dma_chan_seq.sv
module test_dma_chan_seq;
    localparam int AW = 24;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          prog_load;
    logic [AW-1:0] req_addr_init, tgt_addr_init;
    logic [CW-1:0] count_init;
    logic [1:0]    cfg_xfer_mode, cfg_req_dir, cfg_tgt_dir;
    logic          cfg_autoinit, cfg_req_full, cfg_tgt_full, cfg_hw_mask, cfg_tc_irq_en;
    logic          hw_req, sw_req, eop, bus_gnt, xfer_done;
    logic          bus_req, chan_on, tc, irq;
    logic [AW-1:0] req_addr, tgt_addr;
    logic [CW-1:0] count;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  all_done = 0;

    always #10 clk = ~clk;

    dma_chan_seq #(.AW(AW), .CW(CW)) i_dma_chan_seq (.*);

    typedef struct packed {
        logic [1:0]    mode;
        logic [1:0]    rdir;
        logic          rfull;
        logic [1:0]    tdir;
        logic          tfull;
        logic [AW-1:0] ra0;
        logic [AW-1:0] ta0;
        logic [CW-1:0] cnt0;
        logic [AW-1:0] ra_exp;
        logic [AW-1:0] ta_exp;
    } vec_t;

    // Whole buffers: mode, step setup, start values, expected final addresses.
    localparam vec_t VECS [4] = '{
        '{2'd0, 2'd0, 1'b1, 2'd0, 1'b1, 24'h00FFFE, 24'h001000, 16'd3, 24'h010002, 24'h001004},
        '{2'd1, 2'd0, 1'b0, 2'd1, 1'b1, 24'h12FFFE, 24'h000002, 16'd3, 24'h120002, 24'hFFFFFE},
        '{2'd2, 2'd2, 1'b1, 2'd1, 1'b0, 24'h345678, 24'h560001, 16'd3, 24'h345678, 24'h56FFFD},
        '{2'd1, 2'd1, 1'b1, 2'd0, 1'b0, 24'h100000, 24'h00FFFF, 16'd0, 24'h0FFFFF, 24'h000000}
    };

    vec_t cv;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic prog(input logic [1:0] m, input logic [1:0] rd, input logic rf,
                        input logic [1:0] td, input logic tf, input logic [AW-1:0] ra,
                        input logic [AW-1:0] ta, input logic [CW-1:0] c,
                        input logic ai, input logic ie, input logic mk);
        @(negedge clk);
        cfg_xfer_mode = m; cfg_req_dir = rd; cfg_req_full = rf;
        cfg_tgt_dir = td; cfg_tgt_full = tf; req_addr_init = ra;
        tgt_addr_init = ta; count_init = c; cfg_autoinit = ai;
        cfg_tc_irq_en = ie; cfg_hw_mask = mk; prog_load = 1'b1;
        @(negedge clk);
        prog_load = 1'b0;
    endtask

    // Wait for a bus request, grant it, then report one finished transfer.
    task automatic do_xfer(input bit drop_hw, input bit eop_v);
        bit seen = 0;
        for (int i = 0; i < 20 && !seen; i++) begin
            if (bus_req) seen = 1;
            else @(negedge clk);
        end
        n_tests++;
        if (!seen) begin
            n_fail++;
            $display("FAIL R2/R3/R4 request: actual 0 expected 1");
        end
        bus_gnt = 1'b1;
        @(negedge clk);
        bus_gnt = 1'b0; xfer_done = 1'b1; eop = eop_v;
        if (drop_hw) hw_req = 1'b0;
        @(negedge clk);
        xfer_done = 1'b0; eop = 1'b0;
    endtask

    initial begin
        rst_n = 1'b0; prog_load = 0; req_addr_init = '0; tgt_addr_init = '0;
        count_init = '0; cfg_xfer_mode = 0; cfg_autoinit = 0; cfg_req_dir = 0;
        cfg_req_full = 0; cfg_tgt_dir = 0; cfg_tgt_full = 0; cfg_hw_mask = 0;
        cfg_tc_irq_en = 0; hw_req = 0; sw_req = 0; eop = 0; bus_gnt = 0; xfer_done = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 bus_req", bus_req, 0);
        chk("R1 tc", tc, 0);
        chk("R1 irq", irq, 0);
        chk("R1 chan_on", chan_on, 0);
        chk("R1 count", count, 0);
        chk("R1 req_addr", req_addr, 0);
        chk("R1 tgt_addr", tgt_addr, 0);

        // Table of whole buffers across modes and step setups.
        for (int v = 0; v < 4; v++) begin
            cv = VECS[v];
            hw_req = 1'b0;
            prog(cv.mode, cv.rdir, cv.rfull, cv.tdir, cv.tfull, cv.ra0, cv.ta0, cv.cnt0, 0, 0, 0);
            hw_req = 1'b1;
            for (int n = 0; n <= int'(cv.cnt0); n++) begin
                do_xfer(0, 0);
                if (n < int'(cv.cnt0)) begin
                    // R2 release in single mode; R3/R4 hold in block/demand
                    chk("R2/R3/R4 bus_req after done", bus_req, (cv.mode == 2'd0) ? 0 : 1);
                    chk("R8 no early tc", tc, 0);
                end
            end
            chk("R8 tc at end", tc, 1);
            chk("R9 disarmed", chan_on, 0);
            chk("R7 req_addr", req_addr, cv.ra_exp);
            chk("R7 tgt_addr", tgt_addr, cv.ta_exp);
            chk("R8 count wrap", count, 16'hFFFF);
            @(negedge clk);
            chk("R8 tc one cycle", tc, 0);
            repeat (4) @(negedge clk);
            chk("R9 request ignored when off", bus_req, 0);
        end

        // R9 prog_load re-arms
        prog(0, 0, 1, 0, 1, 24'h40, 24'h50, 16'd2, 0, 0, 0);
        @(negedge clk);
        chk("R9 rearm bus_req", bus_req, 1);
        hw_req = 1'b0;

        // R6 masked hardware, software pulse starts transfer
        prog(0, 0, 1, 0, 1, 24'h40, 24'h50, 16'd1, 0, 0, 1);
        hw_req = 1'b1;
        repeat (5) @(negedge clk);
        chk("R6 masked hw", bus_req, 0);
        sw_req = 1'b1;
        @(negedge clk);
        sw_req = 1'b0;
        chk("R6 sw starts", bus_req, 1);
        do_xfer(0, 0);
        chk("R6 count", count, 0);
        chk("R2 release", bus_req, 0);
        hw_req = 1'b0;

        // R5 software pulse ignored in demand mode
        prog(2, 0, 1, 0, 1, 24'h40, 24'h50, 16'd2, 0, 0, 1);
        sw_req = 1'b1;
        @(negedge clk);
        sw_req = 1'b0;
        repeat (4) @(negedge clk);
        chk("R5 no request", bus_req, 0);
        chk("R5 count kept", count, 2);
        chk("R5 addr kept", req_addr, 24'h40);

        // R4 demand suspend and resume
        prog(2, 0, 1, 2, 1, 24'h100, 24'h80, 16'd5, 0, 0, 0);
        hw_req = 1'b1;
        do_xfer(0, 0);
        chk("R4 held", bus_req, 1);
        do_xfer(1, 0);
        chk("R4 suspended", bus_req, 0);
        repeat (3) @(negedge clk);
        chk("R4 still idle", bus_req, 0);
        chk("R4 count kept", count, 3);
        chk("R4 addr kept", req_addr, 24'h102);
        hw_req = 1'b1;
        do_xfer(0, 0);
        chk("R4 resume count", count, 2);
        chk("R4 resume addr", req_addr, 24'h103);
        chk("R7 hold target", tgt_addr, 24'h80);
        hw_req = 1'b0;

        // R11 end-of-process with reload and interrupt
        prog(1, 0, 1, 1, 1, 24'h200, 24'h300, 16'd5, 1, 1, 0);
        hw_req = 1'b1;
        do_xfer(0, 0);
        chk("R8 count step", count, 4);
        do_xfer(1, 1);
        chk("R11 tc on eop", tc, 1);
        chk("R12 irq enabled", irq, 1);
        chk("R11 count reload", count, 5);
        chk("R11 req reload", req_addr, 24'h200);
        chk("R11 tgt reload", tgt_addr, 24'h300);
        chk("R10 stays armed", chan_on, 1);
        @(negedge clk);
        chk("R12 irq pulse ends", irq, 0);

        // R10 reload at terminal count, interrupt disabled
        prog(1, 0, 1, 0, 1, 24'h10, 24'h20, 16'd1, 1, 0, 0);
        hw_req = 1'b1;
        do_xfer(0, 0);
        do_xfer(1, 0);
        chk("R8 tc at zero", tc, 1);
        chk("R12 irq disabled", irq, 0);
        chk("R10 count reload", count, 1);
        chk("R10 addr reload", req_addr, 24'h10);
        chk("R10 armed", chan_on, 1);

        all_done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!all_done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule